// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two timer/counter channels. Each channel owns a pair of 8-bit count bytes (low and high) that can be read and written through a small register port. A shared configuration register picks each channel's source, gating and operating mode. A shared control register holds the run bits and the sticky overflow flags. Each channel counts either the cycles on which `tick_en` is high or falling edges on its own external count pin. Counting can also be made to depend on a per-channel gate pin.

Four modes reuse the same count bytes:
- a 13-bit count, where five low-byte bits act as a prescaler in front of the high byte;
- a cascaded 16-bit count;
- an 8-bit count with automatic reload from the high byte;
- a split mode. In split mode, channel 0's high byte becomes an extra tick-only 8-bit counter that is run by channel 1's run bit and reports through channel 1's flag. When channel 1 is put in split mode, it freezes.

Software starts a channel by setting its run bit. It then polls or reacts to `ovf_flag` and clears a flag by writing zero to it.

Top module: `twin_tmr`

## Requirements
- R1: After synchronous reset, every register reads 0 and `ovf_flag` is 0.
- R2: Register addresses are 0 = configuration, 1 = control, 2/3 = channel 0 low/high count, 4/5 = channel 1 low/high count. Other addresses read 0. In the configuration register, channel 1 uses bits 7:4 and channel 0 uses bits 3:0. Each nibble is {gate, ext_sel, mode[1:0]}, high to low. The control register bits 7..0 are {flag1, run1, flag0, run0, aux3, aux2, aux1, aux0}, and the aux bits are plain storage. A write lands on the next clock edge. The read port is combinational.
- R3: A channel advances only when its run bit is 1 and either gate = 0 or its gate pin is 1. With ext_sel = 0, it advances once for each cycle in which `tick_en` is 1.
- R4: With ext_sel = 1, the channel's count pin passes through two synchronizer flops. A 1-to-0 change that is seen before clock edge k counts at edge k+2.
- R5: Mode 00 counts {high byte, low byte[4:0]} as 13 bits. Low byte bits 7:5 are never changed by counting. The wrap from 0x1FFF to 0 is an overflow.
- R6: Mode 01 counts {high, low} as 16 bits. The wrap from 0xFFFF to 0 is an overflow.
- R7: Mode 10 counts the low byte. On a step from 0xFF, the low byte takes the value of the high byte and an overflow is signalled.
- R8: In mode 11, channel 0's low byte is an 8-bit counter under channel 0's own controls, and its wrap sets flag0. Channel 0's high byte advances on every `tick_en` cycle while run1 = 1, ignoring gate and ext_sel, and its wrap sets flag1. While channel 0 is in mode 11, overflows of channel 1 set no flag.
- R9: When channel 1 is in mode 11, its count bytes hold their values.
- R10: An overflow of channel 0 sets flag0 and an overflow of channel 1 sets flag1. A flag stays set until software writes a 0 to it. A flag set in the same cycle as a write to the control register wins over that write. `ovf_flag` = {flag1, flag0}.
- R11: A write to a count byte in the same cycle as a step cancels the step, including any overflow, for every byte that step would change. In modes 00, 01 and 10 this means the whole channel. In mode 11, the two halves of channel 0 are treated independently. The written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Internal count tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| cnt_pin | input | 2 | External count pins, bit n for channel n |
| gate_pin | input | 2 | Gate pins, bit n for channel n |
| ovf_flag | output | 2 | {flag1, flag0} |

## Verification
The assertions assume that the inputs change only between clock edges and that the configuration does not hold an encoding outside the four modes. Since the mode is two bits wide, every encoding is valid. The hold and reload properties also assume that a count write is the only way software disturbs a byte. The stimulus drives every input on the falling clock edge. It preloads count bytes through the normal write port so that wraps occur within a few cycles. It deliberately overlaps writes with steps and flag sets, so that the priority rules are exercised rather than avoided.

// File: rtl/twin_tmr_pkg.sv
package twin_tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;
    localparam int ADDR_W = 3;
    localparam int N_CH   = 2;

    typedef enum logic [1:0] {
        MODE_PRE13   = 2'b00,
        MODE_CAS16   = 2'b01,
        MODE_RELOAD8 = 2'b10,
        MODE_SPLIT   = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext_sel;
        tmr_mode_e mode;
    } chan_cfg_t;

    typedef struct packed {
        logic       flag1;
        logic       run1;
        logic       flag0;
        logic       run0;
        logic [3:0] aux;
    } ctl_reg_t;

    localparam logic [ADDR_W-1:0] ADR_CFG = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CTL = 3'd1;

    function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
        return ADDR_W'(2 + 2 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
        return ADDR_W'(3 + 2 * ch);
    endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign fall = last_q & ~sync_q[STAGES-1];

    // R4
    fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        fall |-> $past(sync_q[STAGES-1]));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import twin_tmr_pkg::*;
#(
    parameter bit SPLIT_CAPABLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_cfg_t         cfg,
    input  logic              run,
    input  logic              gate_in,
    input  logic              ext_fall,
    input  logic              tick_en,
    input  logic              split_run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              ovf_main,
    output logic              ovf_aux
);
    localparam int W2 = 2 * BYTE_W;

    logic              bump;
    logic              wr_any;
    logic [BYTE_W-1:0] lo_n, hi_n;
    logic [W2-1:0]     wide_n;

    assign wr_any = wr_lo | wr_hi;
    assign bump   = run & (~cfg.gate | gate_in) & (cfg.ext_sel ? ext_fall : tick_en);
    assign wide_n = {hi, lo} + W2'(1);

    always_comb begin
        lo_n     = lo;
        hi_n     = hi;
        ovf_main = 1'b0;
        ovf_aux  = 1'b0;
        unique case (cfg.mode)
            MODE_PRE13: begin
                if (bump && !wr_any) begin
                    lo_n[PRE_W-1:0] = lo[PRE_W-1:0] + 1'b1;
                    if (&lo[PRE_W-1:0]) begin
                        hi_n     = hi + 1'b1;
                        ovf_main = &hi;
                    end
                end
            end
            MODE_CAS16: begin
                if (bump && !wr_any) begin
                    {hi_n, lo_n} = wide_n;
                    ovf_main     = &{hi, lo};
                end
            end
            MODE_RELOAD8: begin
                if (bump && !wr_any) begin
                    if (&lo) begin
                        lo_n     = hi;
                        ovf_main = 1'b1;
                    end else begin
                        lo_n = lo + 1'b1;
                    end
                end
            end
            MODE_SPLIT: begin
                if (SPLIT_CAPABLE) begin
                    if (bump && !wr_lo) begin
                        lo_n     = lo + 1'b1;
                        ovf_main = &lo;
                    end
                    if (split_run && tick_en && !wr_hi) begin
                        hi_n    = hi + 1'b1;
                        ovf_aux = &hi;
                    end
                end
            end
            default: ;
        endcase
        if (wr_lo) lo_n = wr_data;
        if (wr_hi) hi_n = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_n;
            hi <= hi_n;
        end
    end

    // R9
    frozen_split_chk: assert property (@(posedge clk) disable iff (rst)
        (!SPLIT_CAPABLE && cfg.mode == MODE_SPLIT && !wr_any) |=> ($stable(lo) && $stable(hi)));

    // R5
    prescale_top_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_PRE13 && !wr_lo) |=> $stable(lo[BYTE_W-1:PRE_W]));

    // R7
    reload_val_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_RELOAD8 && ovf_main) |=> (lo == $past(hi)));

    // R3
    halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_any && cfg.mode != MODE_SPLIT) |=> ($stable(lo) && $stable(hi)));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (lo == $past(wr_data)));
endmodule

// File: rtl/twin_tmr.sv
module twin_tmr
    import twin_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [N_CH-1:0]   cnt_pin,
    input  logic [N_CH-1:0]   gate_pin,
    output logic [N_CH-1:0]   ovf_flag
);
    chan_cfg_t [N_CH-1:0] cfg_q;
    ctl_reg_t             ctl_q;
    logic [N_CH-1:0]      fall;
    logic [N_CH-1:0]      run_v;
    logic [N_CH-1:0]      ovf_main, ovf_aux;
    logic [BYTE_W-1:0]    lo_v [N_CH];
    logic [BYTE_W-1:0]    hi_v [N_CH];
    logic                 set0, set1;
    logic                 wr_cfg, wr_ctl;

    assign run_v  = {ctl_q.run1, ctl_q.run0};
    assign wr_cfg = wr_en && (wr_addr == ADR_CFG);
    assign wr_ctl = wr_en && (wr_addr == ADR_CTL);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        tmr_pin_sync #(.STAGES(2)) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (cnt_pin[g]),
            .fall(fall[g])
        );

        tmr_channel #(.SPLIT_CAPABLE(g == 0)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg_q[g]),
            .run      (run_v[g]),
            .gate_in  (gate_pin[g]),
            .ext_fall (fall[g]),
            .tick_en  (tick_en),
            .split_run(ctl_q.run1),
            .wr_lo    (wr_en && (wr_addr == lo_addr(g))),
            .wr_hi    (wr_en && (wr_addr == hi_addr(g))),
            .wr_data  (wr_data),
            .lo       (lo_v[g]),
            .hi       (hi_v[g]),
            .ovf_main (ovf_main[g]),
            .ovf_aux  (ovf_aux[g])
        );
    end

    assign set0 = ovf_main[0];
    assign set1 = ovf_aux[0] | ovf_aux[1] |
                  (ovf_main[1] && cfg_q[0].mode != MODE_SPLIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_cfg) cfg_q <= wr_data;
            if (wr_ctl) ctl_q <= wr_data;
            if (set0) ctl_q.flag0 <= 1'b1;
            if (set1) ctl_q.flag1 <= 1'b1;
        end
    end

    always_comb begin
        case (rd_addr)
            ADR_CFG:    rd_data = cfg_q;
            ADR_CTL:    rd_data = ctl_q;
            lo_addr(0): rd_data = lo_v[0];
            hi_addr(0): rd_data = hi_v[0];
            lo_addr(1): rd_data = lo_v[1];
            hi_addr(1): rd_data = hi_v[1];
            default:    rd_data = '0;
        endcase
    end

    assign ovf_flag = {ctl_q.flag1, ctl_q.flag0};

    // R10
    flag0_set_chk: assert property (@(posedge clk) disable iff (rst)
        set0 |=> ctl_q.flag0);

    // R10
    flag1_set_chk: assert property (@(posedge clk) disable iff (rst)
        set1 |=> ctl_q.flag1);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag != 2'b00 && !wr_ctl) |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag)));

    // R8
    split_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[0].mode == MODE_SPLIT && !ovf_aux[0] && !ctl_q.flag1 && !wr_ctl) |=> !ctl_q.flag1);
endmodule

// File: tb/test_twin_tmr.sv
module test_twin_tmr;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] ovf_flag;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    int    tick_style = 0;
    int    cyc = 0;
    bit    done = 0;

    // reference state
    int m_cfg, m_ctl;
    int m_lo[2], m_hi[2];
    bit s1[2], s2[2], s3[2];

    twin_tmr i_twin_tmr (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model_read(input int a);
        case (a)
            0: return m_cfg;
            1: return m_ctl;
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : ref_model
        bit fall[2];
        bit set0, set1, wlo, whi, b, ovf, gt, ext;
        int cf, md, md0, v, run;
        if (rst) begin
            m_cfg = 0; m_ctl = 0;
            for (int c = 0; c < 2; c++) begin
                m_lo[c] = 0; m_hi[c] = 0; s1[c] = 0; s2[c] = 0; s3[c] = 0;
            end
        end else begin
            set0 = 0; set1 = 0;
            md0 = m_cfg & 3;
            for (int c = 0; c < 2; c++) fall[c] = s3[c] & ~s2[c];
            for (int c = 0; c < 2; c++) begin
                cf  = (m_cfg >> (4 * c)) & 15;
                md  = cf & 3;
                gt  = cf[3];
                ext = cf[2];
                run = (m_ctl >> (c == 0 ? 4 : 6)) & 1;
                wlo = wr_en && (wr_addr == 3'(2 + 2 * c));
                whi = wr_en && (wr_addr == 3'(3 + 2 * c));
                b   = (run == 1) && (!gt || gate_pin[c]) && (ext ? fall[c] : tick_en);
                ovf = 0;
                if (md == 0 && b && !wlo && !whi) begin
                    v = (m_hi[c] << 5) | (m_lo[c] & 31);
                    v = v + 1;
                    if (v == 8192) begin v = 0; ovf = 1; end
                    m_hi[c] = v >> 5;
                    m_lo[c] = (m_lo[c] & 224) | (v & 31);
                end else if (md == 1 && b && !wlo && !whi) begin
                    v = m_hi[c] * 256 + m_lo[c] + 1;
                    if (v == 65536) begin v = 0; ovf = 1; end
                    m_hi[c] = v / 256;
                    m_lo[c] = v % 256;
                end else if (md == 2 && b && !wlo && !whi) begin
                    if (m_lo[c] == 255) begin m_lo[c] = m_hi[c]; ovf = 1; end
                    else m_lo[c] = m_lo[c] + 1;
                end else if (md == 3 && c == 0) begin
                    if (b && !wlo) begin
                        if (m_lo[0] == 255) begin m_lo[0] = 0; ovf = 1; end
                        else m_lo[0] = m_lo[0] + 1;
                    end
                    if (m_ctl[6] && tick_en && !whi) begin
                        if (m_hi[0] == 255) begin m_hi[0] = 0; set1 = 1; end
                        else m_hi[0] = m_hi[0] + 1;
                    end
                end
                if (ovf) begin
                    if (c == 0) set0 = 1;
                    else if (md0 != 3) set1 = 1;
                end
                if (wlo) m_lo[c] = wr_data;
                if (whi) m_hi[c] = wr_data;
            end
            if (wr_en && wr_addr == 3'd1) m_ctl = wr_data;
            if (wr_en && wr_addr == 3'd0) m_cfg = wr_data;
            if (set0) m_ctl = m_ctl | 32;
            if (set1) m_ctl = m_ctl | 128;
            for (int c = 0; c < 2; c++) begin
                s3[c] = s2[c]; s2[c] = s1[c]; s1[c] = cnt_pin[c];
            end
        end
    end

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            n_cmp++;
            if (rd_data !== 8'(model_read(rd_addr))) begin
                n_bad++;
                $display("FAIL %s: rd_data[%0d] actual %02h expected %02h",
                         cur_req, rd_addr, rd_data, model_read(rd_addr));
            end
            n_cmp++;
            if (ovf_flag !== {m_ctl[7], m_ctl[5]}) begin
                n_bad++;
                $display("FAIL %s: ovf_flag actual %b expected %b",
                         cur_req, ovf_flag, {m_ctl[7], m_ctl[5]});
            end
        end
    end

    // scan read address and shape tick_en
    always @(negedge clk) begin
        cyc++;
        rd_addr <= (rd_addr == 3'd5) ? 3'd0 : rd_addr + 3'd1;
        case (tick_style)
            0: tick_en <= 1'b1;
            1: tick_en <= (cyc % 3) != 0;
            default: tick_en <= 1'b0;
        endcase
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        tick_style = 2;
        idle(3);
        @(negedge clk) rst = 1'b0;
        cur_req = "R1"; idle(8);

        cur_req = "R2";
        wr(0, 8'hA4); wr(1, 8'h0F);
        wr(2, 8'h12); wr(3, 8'h34); wr(4, 8'h56); wr(5, 8'h78);
        idle(8);
        wr(1, 8'h00); wr(0, 8'h00);

        cur_req = "R3";
        tick_style = 1;
        wr(2, 0); wr(3, 0);
        wr(0, 8'h01); wr(1, 8'h10); idle(40);
        wr(0, 8'h09);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk) gate_pin[0] = (i % 5) < 2;
        end
        wr(1, 8'h00);

        cur_req = "R4";
        wr(0, 8'h55); wr(1, 8'h50);
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            cnt_pin[0] = (i / 2) % 2 == 1;
            cnt_pin[1] = (i / 3) % 2 == 1;
        end
        wr(1, 8'h00);

        cur_req = "R5";
        tick_style = 0;
        wr(0, 8'h00); wr(2, 8'hFC); wr(3, 8'hFF); wr(1, 8'h10); idle(12);
        wr(1, 8'h00);

        cur_req = "R6";
        wr(0, 8'h11); wr(2, 8'hF0); wr(3, 8'hFF); wr(4, 8'hF8); wr(5, 8'hFF);
        wr(1, 8'h50); idle(30);
        wr(1, 8'h00);

        cur_req = "R7";
        wr(0, 8'h22); wr(3, 8'h80); wr(2, 8'hFC); wr(5, 8'hF0); wr(4, 8'hFA);
        wr(1, 8'h50); idle(40);
        wr(1, 8'h00);

        cur_req = "R8";
        wr(0, 8'h03); wr(2, 8'hF0); wr(3, 8'hF8); wr(5, 8'hFF); wr(4, 8'h1E);
        wr(1, 8'h50); idle(30);
        wr(1, 8'h10); idle(10);
        wr(1, 8'h00);

        cur_req = "R9";
        wr(0, 8'h31); wr(4, 8'hFE); wr(5, 8'hFF);
        wr(1, 8'h50); idle(20);
        wr(1, 8'h00);

        cur_req = "R10";
        wr(0, 8'h02); wr(3, 8'hF8); wr(2, 8'hF8);
        for (int i = 0; i < 24; i++) wr(1, 8'h10);
        wr(1, 8'h00); idle(4);

        cur_req = "R11";
        wr(0, 8'h01); wr(2, 8'hFD); wr(3, 8'hFF); wr(1, 8'h10);
        for (int i = 0; i < 10; i++) begin
            wr(2, 8'hFE); idle(1);
        end
        wr(0, 8'h03); wr(1, 8'h50);
        for (int i = 0; i < 10; i++) begin
            wr(3, 8'hFF); wr(2, 8'hFF);
        end
        wr(1, 8'h00); idle(6);

        finish_run();
    end
endmodule